// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block carries out the architectural entry into an exception handler. The core presents one exception code together with the state the entry needs: the current program counter, the current status word, a 4-bit condition field, an error/reason word and the index of the last TLB way used. It then pulses a take strobe. On the next clock edge the unit does four things:
- it records the return address and the saved status word in one of four save-register pairs (primary, critical, machine-check or hypervisor);
- it loads a freshly built status word;
- it jumps to the handler address, which is a per-code vector entry ORed with a common prefix;
- it raises a one-cycle done pulse.

A register-write port loads the vector entries and the prefix. Every vector entry resets to all ones, which means "not defined". Taking an exception whose entry is still all ones flags an error instead of jumping.

Status word bit positions used throughout, where bit 0 is the LSB:

| Bit | Meaning |
|---|---|
| 0 | little-endian (LE) |
| 1 | recoverable (RI) |
| 8 | FP mode 1 |
| 11 | FP mode 0 |
| 12 | machine-check enable (ME) |
| 13 | FP available |
| 16 | exception little-endian (ILE) |
| 18 | power-save |
| 28 | hypervisor (HV) |

Exception codes on `code_i`:

| Code | Exception |
|---|---|
| 0 | none |
| 1 | reset |
| 2 | machine check |
| 3 | critical input |
| 4 | data storage |
| 5 | instruction storage |
| 6 | external |
| 7 | alignment |
| 8 | program |
| 9 | FP unavailable |
| 10 | auxiliary unavailable |
| 11 | vector unavailable |
| 12 | SPE unavailable |
| 13 | watchdog |
| 14 | critical doorbell |
| 15 | software TLB miss |
| 16 | hypervisor decrementer |

Codes 17 to 31 are undefined.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, every output is 0, the prefix is 0 and every vector entry holds all ones.
- R2: For every exception that is taken, the saved status is the current status with the bits of mask 0x783F0000 cleared, ORed with the class-specific bits that the later requirements list.
- R3: The new status keeps bit 12 (ME) of the current status and clears every other bit, before the per-class settings of bits 0, 1, 12 and 28 are applied.
- R4: A machine check (code 2) clears bit 12 in the new status. It writes the machine-check pair and writes the same two values into the critical pair. If bit 12 of the current status is 0 when a machine check is taken, `checkstop_o` rises and then stays high until reset.
- R5: Alignment, FP-unavailable, auxiliary-unavailable, vector-unavailable and SPE-unavailable exceptions (codes 7, 9, 10, 11, 12) save PC−4, and so do program exceptions with reason 1, 2 or 3. All other taken exceptions save PC.
- R6: A program exception (code 8) decodes its reason from `err_i[1:0]` and ORs the matching bit into the saved status: 0 is floating point (0x00100000), 1 is illegal instruction (0x00080000), 2 is privileged (0x00040000), 3 is trap (0x00020000).
- R7: A floating-point program exception (code 8, reason 0) is dropped when FP available (bit 13) is 0, or when both FP mode bits (11 and 8) are 0. A dropped exception changes no output and raises neither `done_o` nor `vec_err_o`. If the two mode bits are equal the exception saves PC. If they differ it also ORs 0x00010000 into the saved status and saves PC−4.
- R8: Reset (code 1) taken with power-save (bit 18) set ORs 0x00010000 into the saved status. Taken with bit 18 clear, it clears bit 12 in the new status.
- R9: Critical input, watchdog and critical doorbell (codes 3, 13, 14) write the critical pair. Hypervisor decrementer (code 16) writes the hypervisor pair, sets bit 28 in the new status and copies bit 1 from the current status. All other codes write the primary pair. Pairs that are not selected keep their values.
- R10: A software TLB miss (code 15) ORs three values into the saved status: `cr_i` shifted left by 28, `err_i`, and the way index ((last_way+1) & (ways−1)) shifted left by 17.
- R11: The new PC is the vector entry for the code ORed with the prefix. If that entry is all ones, or the code is 17 to 31, the unit pulses `vec_err_o` for one cycle and changes nothing else. Code 0 is ignored.
- R12: If bit 16 (ILE) of the current status is set, bit 0 (LE) of the new status is set.
- R13: Configuration writes go through `cfg_we_i`. With `cfg_sel_i[5]` high they load the prefix; with it low they load the vector entry selected by `cfg_sel_i[4:0]`. A take strobe sampled on one clock edge updates every output on that same edge, and `done_o` is high for exactly the following cycle.
- R14: An instruction storage exception (code 5) ORs `err_i` into the saved status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| take_i | input | 1 | take the presented exception |
| code_i | input | 5 | exception code |
| err_i | input | 32 | error/reason word |
| pc_i | input | 32 | current program counter |
| msr_i | input | 32 | current status word |
| cr_i | input | 4 | condition field |
| last_way_i | input | 1 | last TLB way used |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_sel_i | input | 6 | bit 5 selects the prefix, bits 4:0 select a vector entry |
| cfg_data_i | input | 32 | configuration write data |
| pc_o | output | 32 | new program counter (handler address) |
| msr_o | output | 32 | new status word |
| srr0_o | output | 32 | primary pair, return address |
| srr1_o | output | 32 | primary pair, saved status |
| csrr0_o | output | 32 | critical pair, return address |
| csrr1_o | output | 32 | critical pair, saved status |
| mcsrr0_o | output | 32 | machine-check pair, return address |
| mcsrr1_o | output | 32 | machine-check pair, saved status |
| hsrr0_o | output | 32 | hypervisor pair, return address |
| hsrr1_o | output | 32 | hypervisor pair, saved status |
| done_o | output | 1 | one-cycle pulse after an entry is taken |
| vec_err_o | output | 1 | one-cycle pulse after an undefined vector or code |
| checkstop_o | output | 1 | sticky checkstop flag |

## Verification
The bench aims at these failure modes:
- The floating-point program exception, in all three outcomes (dropped, equal mode bits, differing mode bits). A design that decoded the modes wrongly would either jump when it should stay silent, or save the wrong return address.
- Machine checks with ME both set and clear. A wrong design would miss the checkstop, fail to hold it, or leave the critical pair stale.
- The reset-from-power-save split and the hypervisor-decrementer copy of the recoverable bit.
- A TLB miss with way wraparound, where misplaced shifts or fields show up directly in the saved status.
- Vector entries overwritten with all ones, and undefined codes. Both must leave every register untouched.

A constrained-random run over all codes then checks every output against the bench model, so a corrupted save pair is exposed even on an unrelated class.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    EXC_NONE   = 5'd0,
    EXC_RESET  = 5'd1,
    EXC_MCHECK = 5'd2,
    EXC_CRIT   = 5'd3,
    EXC_DSTOR  = 5'd4,
    EXC_ISTOR  = 5'd5,
    EXC_EXT    = 5'd6,
    EXC_ALIGN  = 5'd7,
    EXC_PROG   = 5'd8,
    EXC_FPU    = 5'd9,
    EXC_AUX    = 5'd10,
    EXC_VEC    = 5'd11,
    EXC_SPE    = 5'd12,
    EXC_WDOG   = 5'd13,
    EXC_CDB    = 5'd14,
    EXC_TLBM   = 5'd15,
    EXC_HDEC   = 5'd16
  } exc_code_e;

  typedef enum logic [1:0] {
    PAIR_PRI  = 2'd0,
    PAIR_CRIT = 2'd1,
    PAIR_MC   = 2'd2,
    PAIR_HYP  = 2'd3
  } save_pair_e;

  // status bit positions
  localparam int ST_LE  = 0;
  localparam int ST_RI  = 1;
  localparam int ST_FE1 = 8;
  localparam int ST_FE0 = 11;
  localparam int ST_ME  = 12;
  localparam int ST_FP  = 13;
  localparam int ST_ILE = 16;
  localparam int ST_POW = 18;
  localparam int ST_HV  = 28;

  localparam logic [31:0] SAVE_CLR_MASK = 32'h783F_0000;
  localparam logic [31:0] RSN_FP       = 32'h0010_0000;
  localparam logic [31:0] RSN_ILL      = 32'h0008_0000;
  localparam logic [31:0] RSN_PRIV     = 32'h0004_0000;
  localparam logic [31:0] RSN_TRAP     = 32'h0002_0000;
  localparam logic [31:0] RSN_AUX      = 32'h0001_0000;

  localparam int CR_SHIFT  = 28;
  localparam int WAY_SHIFT = 17;
endpackage

// File: rtl/exc_vector_table.sv
module exc_vector_table #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W:0]   sel_i,
  input  logic [XLEN-1:0]   data_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   vec_o,
  output logic [XLEN-1:0]   prefix_o
);
  localparam int NUM_VEC = 1 << CODE_W;

  logic [XLEN-1:0] tab [NUM_VEC];
  logic [XLEN-1:0] prefix_q;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    logic [XLEN-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '1;
      else if (we_i && !sel_i[CODE_W] && sel_i[CODE_W-1:0] == CODE_W'(g)) ent_q <= data_i;
    end
    assign tab[g] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prefix_q <= '0;
    else if (we_i && sel_i[CODE_W]) prefix_q <= data_i;
  end

  assign vec_o    = tab[code_i];
  assign prefix_o = prefix_q;
endmodule

// File: rtl/exc_status_builder.sv
module exc_status_builder
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int WAYS  = 2,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [XLEN-1:0]   err_i,
  input  logic [3:0]        cr_i,
  input  logic [WAY_W-1:0]  last_way_i,
  output logic [XLEN-1:0]   save_addr_o,
  output logic [XLEN-1:0]   saved_msr_o,
  output logic [XLEN-1:0]   new_msr_o,
  output save_pair_e        pair_o,
  output logic              drop_o,
  output logic              known_o
);
  logic [XLEN-1:0]  sv, nm;
  logic             cur;
  logic [WAY_W-1:0] next_way;

  // power-of-two ways: truncation is the wrap
  assign next_way = last_way_i + WAY_W'(1);

  always_comb begin
    sv        = msr_i & ~XLEN'(SAVE_CLR_MASK);
    nm        = '0;
    nm[ST_ME] = msr_i[ST_ME];
    cur       = 1'b0;
    pair_o    = PAIR_PRI;
    drop_o    = 1'b0;
    known_o   = 1'b1;
    case (code_i)
      EXC_RESET: begin
        if (msr_i[ST_POW]) sv = sv | XLEN'(RSN_AUX);
        else nm[ST_ME] = 1'b0;
      end
      EXC_MCHECK: begin
        nm[ST_ME] = 1'b0;
        pair_o    = PAIR_MC;
      end
      EXC_CRIT, EXC_WDOG, EXC_CDB: pair_o = PAIR_CRIT;
      EXC_ISTOR: sv = sv | err_i;
      EXC_DSTOR, EXC_EXT: ;
      EXC_ALIGN, EXC_FPU, EXC_AUX, EXC_VEC, EXC_SPE: cur = 1'b1;
      EXC_PROG: begin
        case (err_i[1:0])
          2'd0: begin
            if (!msr_i[ST_FP] || (!msr_i[ST_FE0] && !msr_i[ST_FE1])) begin
              drop_o = 1'b1;
            end else begin
              sv = sv | XLEN'(RSN_FP);
              if (msr_i[ST_FE0] != msr_i[ST_FE1]) begin
                sv  = sv | XLEN'(RSN_AUX);
                cur = 1'b1;
              end
            end
          end
          2'd1: begin sv = sv | XLEN'(RSN_ILL);  cur = 1'b1; end
          2'd2: begin sv = sv | XLEN'(RSN_PRIV); cur = 1'b1; end
          default: begin sv = sv | XLEN'(RSN_TRAP); cur = 1'b1; end
        endcase
      end
      EXC_TLBM: begin
        sv = sv | (XLEN'(cr_i) << CR_SHIFT) | err_i | (XLEN'(next_way) << WAY_SHIFT);
      end
      EXC_HDEC: begin
        pair_o    = PAIR_HYP;
        nm[ST_HV] = 1'b1;
        nm[ST_RI] = msr_i[ST_RI];
      end
      default: known_o = 1'b0;
    endcase
    if (msr_i[ST_ILE]) nm[ST_LE] = 1'b1;
  end

  assign saved_msr_o = sv;
  assign new_msr_o   = nm;
  assign save_addr_o = cur ? (pc_i - XLEN'(4)) : pc_i;
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int TLB_WAYS = 2,
  localparam int WAY_W   = (TLB_WAYS > 1) ? $clog2(TLB_WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   err_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [3:0]        cr_i,
  input  logic [WAY_W-1:0]  last_way_i,
  input  logic              cfg_we_i,
  input  logic [CODE_W:0]   cfg_sel_i,
  input  logic [XLEN-1:0]   cfg_data_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   msr_o,
  output logic [XLEN-1:0]   srr0_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic [XLEN-1:0]   csrr0_o,
  output logic [XLEN-1:0]   csrr1_o,
  output logic [XLEN-1:0]   mcsrr0_o,
  output logic [XLEN-1:0]   mcsrr1_o,
  output logic [XLEN-1:0]   hsrr0_o,
  output logic [XLEN-1:0]   hsrr1_o,
  output logic              done_o,
  output logic              vec_err_o,
  output logic              checkstop_o
);
  logic [XLEN-1:0] vec, prefix, save_addr, saved_msr, new_msr;
  save_pair_e      pair;
  logic            drop, known, active, vec_bad, accept, bad_take;

  exc_vector_table #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .data_i  (cfg_data_i),
    .code_i  (code_i),
    .vec_o   (vec),
    .prefix_o(prefix)
  );

  exc_status_builder #(.XLEN(XLEN), .WAYS(TLB_WAYS), .WAY_W(WAY_W)) u_bld (
    .code_i     (code_i),
    .pc_i       (pc_i),
    .msr_i      (msr_i),
    .err_i      (err_i),
    .cr_i       (cr_i),
    .last_way_i (last_way_i),
    .save_addr_o(save_addr),
    .saved_msr_o(saved_msr),
    .new_msr_o  (new_msr),
    .pair_o     (pair),
    .drop_o     (drop),
    .known_o    (known)
  );

  // code 0 and dropped FP exceptions are silent
  assign active   = take_i && (code_i != EXC_NONE) && !drop;
  assign vec_bad  = !known || (vec == '1);
  assign accept   = active && !vec_bad;
  assign bad_take = active && vec_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o        <= '0;
      msr_o       <= '0;
      srr0_o      <= '0;
      srr1_o      <= '0;
      csrr0_o     <= '0;
      csrr1_o     <= '0;
      mcsrr0_o    <= '0;
      mcsrr1_o    <= '0;
      hsrr0_o     <= '0;
      hsrr1_o     <= '0;
      done_o      <= 1'b0;
      vec_err_o   <= 1'b0;
      checkstop_o <= 1'b0;
    end else begin
      done_o    <= accept;
      vec_err_o <= bad_take;
      if (accept) begin
        pc_o  <= vec | prefix;
        msr_o <= new_msr;
        case (pair)
          PAIR_PRI:  begin srr0_o <= save_addr; srr1_o <= saved_msr; end
          PAIR_CRIT: begin csrr0_o <= save_addr; csrr1_o <= saved_msr; end
          PAIR_MC: begin
            mcsrr0_o <= save_addr; mcsrr1_o <= saved_msr;
            csrr0_o  <= save_addr; csrr1_o  <= saved_msr;
          end
          default:   begin hsrr0_o <= save_addr; hsrr1_o <= saved_msr; end
        endcase
        if (code_i == EXC_MCHECK && !msr_i[ST_ME]) checkstop_o <= 1'b1;
      end
    end
  end

  localparam logic [XLEN-1:0] NEW_KEEP =
    (XLEN'(1) << ST_ME) | (XLEN'(1) << ST_LE) | (XLEN'(1) << ST_HV) | (XLEN'(1) << ST_RI);

  a_r4_checkstop_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checkstop_o |=> checkstop_o);
  a_r4_mc_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && code_i == EXC_MCHECK && !msr_i[ST_ME]) |=> checkstop_o);
  a_r4_mc_me_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && code_i == EXC_MCHECK) |=> !msr_o[ST_ME]);
  a_r3_new_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ((msr_o & ~NEW_KEEP) == '0));
  a_r2_ext_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && code_i == EXC_EXT) |=> (srr1_o == ($past(msr_i) & ~XLEN'(SAVE_CLR_MASK))));
  a_r12_le: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && msr_i[ST_ILE]) |=> msr_o[ST_LE]);
  a_r11_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_err_o |-> !done_o);
  a_r13_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> done_o);
  a_r7_drop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && drop) |=> (!done_o && !vec_err_o && $stable(msr_o)));
endmodule

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        take_i = 1'b0;
  logic [4:0]  code_i = '0;
  logic [31:0] err_i = '0, pc_i = '0, msr_i = '0;
  logic [3:0]  cr_i = '0;
  logic        last_way_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_sel_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic [31:0] pc_o, msr_o, srr0_o, srr1_o, csrr0_o, csrr1_o;
  logic [31:0] mcsrr0_o, mcsrr1_o, hsrr0_o, hsrr1_o;
  logic        done_o, vec_err_o, checkstop_o;

  always #5 clk = ~clk;

  exc_entry_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .take_i(take_i), .code_i(code_i), .err_i(err_i),
    .pc_i(pc_i), .msr_i(msr_i), .cr_i(cr_i), .last_way_i(last_way_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
    .pc_o(pc_o), .msr_o(msr_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
    .csrr0_o(csrr0_o), .csrr1_o(csrr1_o), .mcsrr0_o(mcsrr0_o), .mcsrr1_o(mcsrr1_o),
    .hsrr0_o(hsrr0_o), .hsrr1_o(hsrr1_o), .done_o(done_o), .vec_err_o(vec_err_o),
    .checkstop_o(checkstop_o)
  );

  int n_chk = 0, n_err = 0;
  bit fin = 0;
  logic [31:0] mtab [32];
  logic [31:0] mpre = '0;
  logic [31:0] e_pc = '0, e_msr = '0;
  logic [31:0] e_sv [8];
  bit e_cs = 0, e_done = 0, e_verr = 0;

  task automatic chk(string tag, string fld, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, a, e);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "pc", pc_o, e_pc);
    chk(tag, "msr", msr_o, e_msr);
    chk(tag, "srr0", srr0_o, e_sv[0]);
    chk(tag, "srr1", srr1_o, e_sv[1]);
    chk(tag, "csrr0", csrr0_o, e_sv[2]);
    chk(tag, "csrr1", csrr1_o, e_sv[3]);
    chk(tag, "mcsrr0", mcsrr0_o, e_sv[4]);
    chk(tag, "mcsrr1", mcsrr1_o, e_sv[5]);
    chk(tag, "hsrr0", hsrr0_o, e_sv[6]);
    chk(tag, "hsrr1", hsrr1_o, e_sv[7]);
    chk(tag, "done", {31'b0, done_o}, {31'b0, e_done});
    chk(tag, "vec_err", {31'b0, vec_err_o}, {31'b0, e_verr});
    chk(tag, "checkstop", {31'b0, checkstop_o}, {31'b0, e_cs});
  endtask

  // expected behaviour from the requirements
  task automatic model(logic [4:0] c, logic [31:0] pc, logic [31:0] m, logic [31:0] er,
                       logic [3:0] crv, logic lw);
    logic [31:0] sv, nm, sa;
    int pair;
    bit drop, known, cur;
    sv = m & ~32'h783F0000; nm = '0; nm[12] = m[12];
    pair = 0; drop = 0; known = 1; cur = 0;
    case (c)
      5'd1: if (m[18]) sv |= 32'h00010000; else nm[12] = 1'b0;
      5'd2: begin nm[12] = 1'b0; pair = 2; end
      5'd3, 5'd13, 5'd14: pair = 1;
      5'd4, 5'd6: ;
      5'd5: sv |= er;
      5'd7, 5'd9, 5'd10, 5'd11, 5'd12: cur = 1;
      5'd8: begin
        if (er[1:0] == 2'd0) begin
          if (!m[13] || (!m[11] && !m[8])) drop = 1;
          else begin
            sv |= 32'h00100000;
            if (m[11] != m[8]) begin sv |= 32'h00010000; cur = 1; end
          end
        end else if (er[1:0] == 2'd1) begin sv |= 32'h00080000; cur = 1; end
        else if (er[1:0] == 2'd2) begin sv |= 32'h00040000; cur = 1; end
        else begin sv |= 32'h00020000; cur = 1; end
      end
      5'd15: sv |= ({28'b0, crv} << 28) | er | ({31'b0, ~lw} << 17);
      5'd16: begin pair = 3; nm[28] = 1'b1; nm[1] = m[1]; end
      default: known = 0;
    endcase
    if (m[16]) nm[0] = 1'b1;
    sa = cur ? pc - 32'd4 : pc;
    e_done = 0; e_verr = 0;
    if (c == 5'd0 || drop) begin
    end else if (!known || mtab[c] == 32'hFFFF_FFFF) begin
      e_verr = 1;
    end else begin
      e_done = 1;
      e_pc = mtab[c] | mpre;
      e_msr = nm;
      e_sv[pair*2] = sa; e_sv[pair*2+1] = sv;
      if (pair == 2) begin e_sv[2] = sa; e_sv[3] = sv; end
      if (c == 5'd2 && !m[12]) e_cs = 1;
    end
  endtask

  task automatic take(string tag, logic [4:0] c, logic [31:0] pc, logic [31:0] m,
                      logic [31:0] er, logic [3:0] crv, logic lw);
    @(negedge clk);
    code_i = c; pc_i = pc; msr_i = m; err_i = er; cr_i = crv; last_way_i = lw;
    take_i = 1'b1;
    @(posedge clk);
    model(c, pc, m, er, crv, lw);
    @(negedge clk);
    take_i = 1'b0;
    check_all(tag);
  endtask

  task automatic cfg(logic [5:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d;
    @(posedge clk);
    if (sel[5]) mpre = d; else mtab[sel[4:0]] = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!fin) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 32; i++) mtab[i] = 32'hFFFF_FFFF;
    for (int i = 0; i < 8; i++) e_sv[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1");
    // R1/R11: undefined table right after reset
    take("R1", 5'd6, 32'h100, 32'h0, 32'h0, 4'h0, 1'b0);
    chk("R1", "vec_err", {31'b0, vec_err_o}, 32'd1);

    // R13: configure table and prefix
    for (int c = 1; c <= 16; c++) cfg({1'b0, 5'(c)}, 32'(c) << 8);
    cfg(6'h20, 32'hFFF0_0000);

    take("R2", 5'd6, 32'h0000_2000, 32'hFFFF_FFFF, 32'h0, 4'h0, 1'b0);
    chk("R2", "srr1", srr1_o, 32'h87C0_FFFF);
    chk("R12", "msr", msr_o, 32'h0000_1001);
    chk("R11", "pc", pc_o, 32'hFFF0_0600);
    chk("R13", "done", {31'b0, done_o}, 32'd1);
    @(negedge clk);
    chk("R13", "done_drop", {31'b0, done_o}, 32'd0);

    take("R3", 5'd4, 32'h3000, 32'h0000_0001, 32'h0, 4'h0, 1'b0);
    chk("R3", "msr", msr_o, 32'h0);

    take("R5", 5'd7, 32'h0000_1000, 32'h0, 32'h0, 4'h0, 1'b0);
    chk("R5", "srr0", srr0_o, 32'h0000_0FFC);
    take("R5", 5'd12, 32'h0000_1100, 32'h0, 32'h0, 4'h0, 1'b0);
    take("R5", 5'd10, 32'h0000_1200, 32'h0, 32'h0, 4'h0, 1'b0);

    for (int r = 1; r < 4; r++) take("R6", 5'd8, 32'h4000, 32'h0, 32'(r), 4'h0, 1'b0);
    chk("R6", "srr1_trap", srr1_o, 32'h0002_0000);
    // R7: FP reason variants
    take("R7", 5'd8, 32'h5000, 32'h0000_0900, 32'h0, 4'h0, 1'b0); // FP off -> drop
    take("R7", 5'd8, 32'h5000, 32'h0000_2000, 32'h0, 4'h0, 1'b0); // modes 0 -> drop
    take("R7", 5'd8, 32'h5000, 32'h0000_2900, 32'h0, 4'h0, 1'b0); // equal
    chk("R7", "srr0_eq", srr0_o, 32'h5000);
    take("R7", 5'd8, 32'h6000, 32'h0000_2800, 32'h0, 4'h0, 1'b0); // differ
    chk("R7", "srr1_diff", srr1_o, 32'h0011_2800);

    take("R8", 5'd1, 32'h7000, 32'h0004_1000, 32'h0, 4'h0, 1'b0);
    chk("R8", "srr1_pow", srr1_o, 32'h0001_1000);
    take("R8", 5'd1, 32'h7000, 32'h0000_1000, 32'h0, 4'h0, 1'b0);
    chk("R8", "msr_me", msr_o, 32'h0);

    take("R9", 5'd13, 32'h8000, 32'h0, 32'h0, 4'h0, 1'b0);
    take("R9", 5'd14, 32'h8100, 32'h0, 32'h0, 4'h0, 1'b0);
    take("R9", 5'd16, 32'h8200, 32'h0000_1002, 32'h0, 4'h0, 1'b0);
    chk("R9", "msr_hyp", msr_o, 32'h1000_1002);

    take("R4", 5'd2, 32'h9000, 32'h0000_1000, 32'h0, 4'h0, 1'b0);
    chk("R4", "checkstop", {31'b0, checkstop_o}, 32'd0);
    take("R4", 5'd2, 32'h9100, 32'h0, 32'h0, 4'h0, 1'b0);
    chk("R4", "checkstop", {31'b0, checkstop_o}, 32'd1);
    chk("R4", "crit_copy", csrr0_o, 32'h9100);

    take("R10", 5'd15, 32'hA000, 32'h0, 32'h5, 4'hA, 1'b0);
    chk("R10", "srr1", srr1_o, 32'hA002_0005);
    take("R10", 5'd15, 32'hA100, 32'h0, 32'h0, 4'h3, 1'b1);
    chk("R10", "srr1_wrap", srr1_o, 32'h3000_0000);
    take("R14", 5'd5, 32'hB000, 32'h0, 32'h4000_0000, 4'h0, 1'b0);
    chk("R14", "srr1", srr1_o, 32'h4000_0000);

    cfg(6'd6, 32'hFFFF_FFFF);
    take("R11", 5'd6, 32'hC000, 32'h0, 32'h0, 4'h0, 1'b0);
    take("R11", 5'd20, 32'hC100, 32'h0, 32'h0, 4'h0, 1'b0);
    take("R11", 5'd0, 32'hC200, 32'h0, 32'h0, 4'h0, 1'b0);
    cfg(6'd6, 32'h0000_0600);

    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic [4:0] s = 5'($urandom_range(1, 16));
        cfg({1'b0, s}, ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom());
      end
      take("random", 5'($urandom_range(0, 19)), $urandom(), $urandom(), $urandom(),
           4'($urandom()), 1'($urandom()));
    end

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule